// File: doc/BRIEF.md
# Dual-Priority Descriptor Intake Engine

This engine takes DMA read descriptors from two stream sinks, one for ordinary traffic and one for urgent traffic. Each sink follows a ready-latency protocol: the engine raises a sink's ready for one cycle, and the sender may answer with valid exactly three cycles later. The engine has no descriptor storage. It offers one sink at a time and waits out the latency window before it offers again. The urgent sink is always offered first at a descriptor boundary, so it has absolute precedence. A descriptor that is already running is never interrupted.

A latched descriptor is split into read commands of at most 32 dwords. Each command goes out on a zero-latency valid/ready port. The source address advances by the command size. The destination address either advances by the same amount or stays fixed, as the descriptor's fixed-destination flag selects. When the last command is accepted, a one-cycle status pulse reports the descriptor ID and the sink the descriptor came from.

Top module: `desc_intake_engine`

## Requirements
- R1: In the first cycle after a cycle with reset high, both ready outputs, cmd_vld and sts_vld are low.
- R2: Each ready output is high for a single cycle. A sink's descriptor is taken only when that sink's valid is high exactly 3 cycles after its ready was high. Valid in any other cycle is ignored.
- R3: At every descriptor boundary, including leaving reset, the urgent sink is offered first. The ordinary sink is offered 4 cycles later, and only if the urgent window brought no valid. An empty ordinary window is followed 4 cycles later by a new urgent offer. The cycle in which the status pulse is high is also an urgent offer cycle.
- R4: While a descriptor is active, cmd_vld stays high and both ready outputs stay low. Only one descriptor is held at a time, and a pending urgent descriptor waits until the current one has finished.
- R5: Descriptor fields: source address in bits [63:0], destination address in [127:64], dword count in [145:128], fixed-destination flag in bit 148, ID in [159:152].
- R6: Commands carry 32 dwords each, and the last command carries the remainder (1..32). The source address of each command is the previous one plus 4 times the previous length.
- R7: When bit 148 is 1, every command repeats the descriptor's destination address. When it is 0, the destination address advances by 4 times the previous length.
- R8: A dword count of 0 means 2^18 dwords, which is 8192 commands of 32 dwords.
- R9: One cycle after the final command handshake, sts_vld is high for exactly one cycle. sts_id carries the ID and sts_pri is 1 for the urgent sink and 0 for the ordinary sink.
- R10: While cmd_vld is high and cmd_rdy is low, cmd_src, cmd_dst and cmd_len hold their values.
- R11: Bits [173:160], [151:149], 147 and 146 have no effect on the commands or the status.
- R12: The two ready outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nrm_vld | input | 1 | Ordinary sink valid |
| nrm_data | input | 174 | Ordinary sink descriptor |
| nrm_rdy | output | 1 | Ordinary sink ready offer |
| pri_vld | input | 1 | Urgent sink valid |
| pri_data | input | 174 | Urgent sink descriptor |
| pri_rdy | output | 1 | Urgent sink ready offer |
| cmd_vld | output | 1 | Read command valid |
| cmd_rdy | input | 1 | Read command accept |
| cmd_src | output | 64 | Command source address |
| cmd_dst | output | 64 | Command destination address |
| cmd_len | output | 6 | Command length in dwords (1..32) |
| sts_vld | output | 1 | Completion pulse |
| sts_id | output | 8 | Completed descriptor ID |
| sts_pri | output | 1 | Completed descriptor came from the urgent sink |

## Verification
Two things happen in the cycle after the final command handshake: the completion pulse is emitted, and the urgent sink is offered again. The bench provokes this overlap by running a long ordinary descriptor while an urgent sender and a second ordinary sender are both waiting. In that cycle it checks that sts_vld, the ID and pri_rdy are all high together. It then checks that the urgent descriptor's commands come out before those of the waiting ordinary descriptor.

// File: rtl/desc_intake_engine.sv
module desc_intake_engine #(
  parameter int DESC_W  = 174,
  parameter int ADDR_W  = 64,
  parameter int CNT_W   = 18,
  parameter int ID_W    = 8,
  parameter int RDY_LAT = 3,
  parameter int MAX_DW  = 32,
  localparam int LEN_W  = $clog2(MAX_DW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nrm_vld,
  input  logic [DESC_W-1:0] nrm_data,
  output logic              nrm_rdy,
  input  logic              pri_vld,
  input  logic [DESC_W-1:0] pri_data,
  output logic              pri_rdy,
  output logic              cmd_vld,
  input  logic              cmd_rdy,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              sts_vld,
  output logic [ID_W-1:0]   sts_id,
  output logic              sts_pri
);
  localparam int REM_W   = CNT_W + 1;
  localparam int LAT_W   = $clog2(RDY_LAT + 1);
  localparam int DST_LO  = ADDR_W;
  localparam int CNT_LO  = 2 * ADDR_W;
  localparam int SGL_BIT = CNT_LO + CNT_W + 2;
  localparam int ID_LO   = SGL_BIT + 4;

  typedef enum logic [2:0] {S_START, S_OFF_P, S_WAIT_P, S_OFF_N, S_WAIT_N, S_BUSY} st_t;

  st_t               st;
  logic [LAT_W-1:0]  lat_cnt;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [REM_W-1:0]  rem_q;
  logic              sgl_q, pri_q;
  logic [ID_W-1:0]   id_q;

  wire at_slot = lat_cnt == LAT_W'(RDY_LAT);
  wire take_p  = (st == S_WAIT_P) && at_slot && pri_vld;
  wire take_n  = (st == S_WAIT_N) && at_slot && nrm_vld;
  wire [DESC_W-1:0] pick = take_p ? pri_data : nrm_data;
  wire [CNT_W-1:0]  cnt_raw = pick[CNT_LO +: CNT_W];
  wire [REM_W-1:0]  cnt_in  = (cnt_raw == '0) ? (REM_W'(1) << CNT_W) : REM_W'(cnt_raw);
  wire unused_rsv = ^{pick[DESC_W-1:ID_LO+ID_W], pick[ID_LO-1:SGL_BIT+1],
                      pick[SGL_BIT-1:CNT_LO+CNT_W]};

  assign pri_rdy = st == S_OFF_P;
  assign nrm_rdy = st == S_OFF_N;
  assign cmd_vld = st == S_BUSY;
  assign cmd_src = src_q;
  assign cmd_dst = dst_q;
  assign cmd_len = (rem_q > REM_W'(MAX_DW)) ? LEN_W'(MAX_DW) : rem_q[LEN_W-1:0];

  wire fire = cmd_vld && cmd_rdy;
  wire last = fire && (rem_q == REM_W'(cmd_len));
  wire [ADDR_W-1:0] step = ADDR_W'({cmd_len, 2'b00});

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_START;
      lat_cnt <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      sgl_q   <= 1'b0;
      pri_q   <= 1'b0;
      id_q    <= '0;
      sts_vld <= 1'b0;
      sts_id  <= '0;
      sts_pri <= 1'b0;
    end else begin
      sts_vld <= last;
      if (last) begin
        sts_id  <= id_q;
        sts_pri <= pri_q;
      end
      if (take_p || take_n) begin
        src_q <= pick[ADDR_W-1:0];
        dst_q <= pick[DST_LO +: ADDR_W];
        rem_q <= cnt_in;
        sgl_q <= pick[SGL_BIT];
        id_q  <= pick[ID_LO +: ID_W];
        pri_q <= take_p;
      end
      case (st)
        S_START: st <= S_OFF_P;
        S_OFF_P: begin
          st      <= S_WAIT_P;
          lat_cnt <= LAT_W'(1);
        end
        S_WAIT_P: begin
          if (at_slot) st <= pri_vld ? S_BUSY : S_OFF_N;
          else lat_cnt <= lat_cnt + LAT_W'(1);
        end
        S_OFF_N: begin
          st      <= S_WAIT_N;
          lat_cnt <= LAT_W'(1);
        end
        S_WAIT_N: begin
          if (at_slot) st <= nrm_vld ? S_BUSY : S_OFF_P;
          else lat_cnt <= lat_cnt + LAT_W'(1);
        end
        S_BUSY: begin
          if (fire) begin
            src_q <= src_q + step;
            if (!sgl_q) dst_q <= dst_q + step;
            rem_q <= rem_q - REM_W'(cmd_len);
            if (last) st <= S_OFF_P;
          end
        end
        default: st <= S_START;
      endcase
    end
  end
endmodule

// File: rtl/desc_intake_engine_chk.sv
module desc_intake_engine_chk #(
  parameter int ADDR_W = 64,
  parameter int MAX_DW = 32,
  localparam int LEN_W = $clog2(MAX_DW + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              nrm_rdy,
  input logic              pri_rdy,
  input logic              cmd_vld,
  input logic              cmd_rdy,
  input logic [ADDR_W-1:0] cmd_src,
  input logic [ADDR_W-1:0] cmd_dst,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              sts_vld
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!nrm_rdy && !pri_rdy && !cmd_vld && !sts_vld)); // R1
  AST_PRI_RDY_PULSE: assert property (@(posedge clk) disable iff (rst) pri_rdy |=> !pri_rdy); // R2
  AST_NRM_RDY_PULSE: assert property (@(posedge clk) disable iff (rst) nrm_rdy |=> !nrm_rdy); // R2
  AST_PRI_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst) sts_vld |-> pri_rdy); // R3
  AST_NO_OFFER_BUSY: assert property (@(posedge clk) disable iff (rst) cmd_vld |-> (!nrm_rdy && !pri_rdy)); // R4
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst) cmd_vld |-> (cmd_len != '0 && cmd_len <= LEN_W'(MAX_DW))); // R6
  AST_STS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) sts_vld |=> !sts_vld); // R9
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst) (cmd_vld && !cmd_rdy) |=> (cmd_vld && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len))); // R10
  AST_RDY_EXCL: assert property (@(posedge clk) disable iff (rst) !(nrm_rdy && pri_rdy)); // R12
endmodule

bind desc_intake_engine desc_intake_engine_chk #(.ADDR_W(ADDR_W), .MAX_DW(MAX_DW)) u_chk (
  .clk(clk), .rst(rst), .nrm_rdy(nrm_rdy), .pri_rdy(pri_rdy), .cmd_vld(cmd_vld),
  .cmd_rdy(cmd_rdy), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len), .sts_vld(sts_vld)
);

// File: tb/desc_intake_engine_bench.sv
module desc_intake_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrm_vld = 1'b0, pri_vld = 1'b0, cmd_rdy = 1'b0;
  logic [173:0] nrm_data = '0, pri_data = '0;
  logic nrm_rdy, pri_rdy, cmd_vld, sts_vld, sts_pri;
  logic [63:0] cmd_src, cmd_dst;
  logic [5:0] cmd_len;
  logic [7:0] sts_id;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  desc_intake_engine u_desc_intake_engine (
    .clk(clk), .rst(rst),
    .nrm_vld(nrm_vld), .nrm_data(nrm_data), .nrm_rdy(nrm_rdy),
    .pri_vld(pri_vld), .pri_data(pri_data), .pri_rdy(pri_rdy),
    .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .sts_vld(sts_vld), .sts_id(sts_id), .sts_pri(sts_pri)
  );

  typedef struct packed {
    logic pri; logic sgl; logic bp; logic rsv;
    logic [7:0] id; logic [17:0] cnt; logic [63:0] src; logic [63:0] dst;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 18'd1,  64'h0000_0000_0000_1000, 64'h0000_0000_8000_0000},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 18'd70, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_2000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 18'd64, 64'h0000_0000_0000_0040, 64'h0000_0000_0000_5000},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 18'd33, 64'h0000_0000_00AB_0000, 64'h0000_0000_0007_7000},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 18'd31, 64'h0000_0000_0000_0F00, 64'h0000_0000_0000_3000},
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h7E, 18'd0,  64'h0000_0000_1000_0000, 64'h0000_0000_2000_0000}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [173:0] mk(input vec_t v);
    return {v.rsv ? 14'h3FFF : 14'h0, v.id, v.rsv ? 3'b101 : 3'b000, v.sgl,
            v.rsv ? 2'b11 : 2'b00, v.cnt, v.dst, v.src};
  endfunction

  task automatic send(input vec_t v);
    if (v.pri) begin
      do @(negedge clk); while (!pri_rdy);
      repeat (3) @(negedge clk);
      pri_vld = 1'b1; pri_data = mk(v);
      @(negedge clk);
      pri_vld = 1'b0; pri_data = '0;
    end else begin
      do @(negedge clk); while (!nrm_rdy);
      repeat (3) @(negedge clk);
      nrm_vld = 1'b1; nrm_data = mk(v);
      @(negedge clk);
      nrm_vld = 1'b0; nrm_data = '0;
    end
  endtask

  task automatic collect(input vec_t v);
    int unsigned rem = (v.cnt == 0) ? (1 << 18) : int'(v.cnt);
    int unsigned ncmd = 0;
    int unsigned exp_cmds = (rem + 31) / 32;
    logic [63:0] es = v.src, ed = v.dst;
    int ph = 0;
    string tag = v.rsv ? "R11" : "R6";
    while (!cmd_vld) @(negedge clk);
    while (rem > 0) begin
      int unsigned el = (rem > 32) ? 32 : rem;
      cmd_rdy = v.bp ? (ph % 3 != 0) : 1'b1;
      ph++;
      chk(cmd_vld, "R4 busy", 64'(cmd_vld), 64'd1);
      chk(!nrm_rdy && !pri_rdy, "R4 ready", 64'({nrm_rdy, pri_rdy}), 64'd0);
      chk(cmd_src == es, (ncmd == 0) ? "R5 src" : tag, cmd_src, es);
      chk(cmd_dst == ed, v.sgl ? "R7 fixed dst" : "R7 dst", cmd_dst, ed);
      chk(cmd_len == 6'(el), (v.cnt == 0) ? "R8 len" : "R10 len", 64'(cmd_len), 64'(el));
      if (cmd_rdy) begin
        es += 64'(el) * 4;
        if (!v.sgl) ed += 64'(el) * 4;
        rem -= el;
        ncmd++;
      end
      @(negedge clk);
    end
    cmd_rdy = 1'b0;
    chk(ncmd == exp_cmds, (v.cnt == 0) ? "R8 count" : "R6 count", 64'(ncmd), 64'(exp_cmds));
    chk(sts_vld, "R9 pulse", 64'(sts_vld), 64'd1);
    chk(sts_id == v.id, v.rsv ? "R11 id" : "R9 id", 64'(sts_id), 64'(v.id));
    chk(sts_pri == v.pri, "R9 source", 64'(sts_pri), 64'(v.pri));
    chk(pri_rdy, "R3 offer at status", 64'(pri_rdy), 64'd1);
    @(negedge clk);
    chk(!sts_vld, "R9 single cycle", 64'(sts_vld), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t n1, pa, nb;
    repeat (3) @(negedge clk);
    chk(!pri_rdy && !nrm_rdy && !cmd_vld && !sts_vld, "R1 reset",
        64'({pri_rdy, nrm_rdy, cmd_vld, sts_vld}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(pri_rdy && !nrm_rdy, "R3 urgent first", 64'({pri_rdy, nrm_rdy}), 64'b10);
    chk(!(pri_rdy && nrm_rdy), "R12", 64'({pri_rdy, nrm_rdy}), 64'b10);
    nrm_vld = 1'b1; nrm_data = mk(VECS[0]);
    @(negedge clk);
    nrm_vld = 1'b0; nrm_data = '0;
    chk(!pri_rdy && !nrm_rdy, "R2 single cycle ready", 64'({pri_rdy, nrm_rdy}), 64'd0);
    pri_vld = 1'b1; pri_data = mk(VECS[1]);
    @(negedge clk);
    pri_vld = 1'b0; pri_data = '0;
    repeat (2) @(negedge clk);
    chk(nrm_rdy && !pri_rdy, "R3 ordinary after 4", 64'({pri_rdy, nrm_rdy}), 64'b01);
    repeat (4) @(negedge clk);
    chk(pri_rdy && !nrm_rdy, "R3 urgent again", 64'({pri_rdy, nrm_rdy}), 64'b10);
    begin
      bit seen = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (cmd_vld) seen = 1'b1;
      end
      chk(!seen, "R2 off-slot valid ignored", 64'(seen), 64'd0);
    end

    for (int i = 0; i < 6; i++) begin
      send(VECS[i]);
      collect(VECS[i]);
    end

    n1 = '{1'b0, 1'b0, 1'b1, 1'b0, 8'h21, 18'd96, 64'h9000, 64'hA000};
    pa = '{1'b1, 1'b0, 1'b0, 1'b0, 8'h42, 18'd40, 64'hB000, 64'hC000};
    nb = '{1'b0, 1'b1, 1'b0, 1'b0, 8'h63, 18'd5,  64'hD000, 64'hE000};
    fork
      begin send(n1); send(nb); end
      begin
        do @(negedge clk); while (!cmd_vld);
        send(pa);
      end
      begin collect(n1); collect(pa); collect(nb); end
    join

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule